// File: doc/BRIEF.md
# Masked GPIO Output Data Register

This block stores the 32-bit output data value for one bank of general-purpose output pins. Software updates that value through a small register bus with address, write enable, write data and read data. Each half of the bank has a masked write port. A single write to that port carries sixteen data bits and sixteen per-bit keep flags, so chosen pins change in one bus cycle and software does not need a read-modify-write sequence.

A third, plain register replaces all 32 bits at once. Every read returns the stored output value and never the level sampled on the pins. The block only holds data values. Direction control, driver enables, input sampling and interrupts belong to other logic.

Top module: `gpo_mask_out`

## Requirements
- R1: After a synchronous active-high reset, the stored output value `gpo_value` is 32'h0000_0000.
- R2: A write to offset 0x0 treats write-data bits 31:16 as keep flags and bits 15:0 as data for output bits 15:0. For each n, a keep flag of 0 loads data bit n into output bit n, and a keep flag of 1 leaves output bit n unchanged. Output bits 31:16 do not change.
- R3: A write to offset 0x4 works the same way on output bits 31:16, with keep flag n and data bit n controlling output bit 16+n. Output bits 15:0 do not change.
- R4: A write to offset 0x8 replaces all 32 output bits with the write data.
- R5: A read of offset 0x0 returns output bits 15:0 in read bits 15:0. A read of offset 0x4 returns output bits 31:16 in read bits 15:0. Read bits 31:16 are zero for both offsets, because the keep flags cannot be read back.
- R6: A read of offset 0x8 returns the full stored 32-bit output value. This is the last value written through any of the three offsets.
- R7: A write lands on the rising edge where write enable is high, and the new value appears at `gpo_value` in the following cycle. While write enable is low, `gpo_value` does not change.
- R8: A write to any offset other than 0x0, 0x4 or 0x8 leaves `gpo_value` unchanged. A read of any such offset returns zero.
- R9: A masked write with all sixteen keep flags set leaves its half of the output unchanged. A masked write with all keep flags clear loads the full sixteen data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpo_value | output | 32 | Stored output data value |

## Verification
A wrong stored bit reaches `gpo_value` one cycle after the write that corrupted it. The read path for the matching offset shows it in the same cycle. Three other faults also show at the ports one cycle after the write: a keep flag whose sense is inverted, a half-bank that is written by mistake, or an unmapped offset that aliases onto a real one. The wrong value then stays on the output until a later write covers that bit. For this reason, each write is followed by a comparison of the output and of a read-back against a reference value. A wrong read mux does not touch the stored state and shows only in `bus_rdata`, in the same cycle as the address.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_LO   = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_HI   = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_FULL = 4'h8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LO   = 2'd1,
        TGT_HI   = 2'd2,
        TGT_FULL = 2'd3
    } gpo_tgt_e;

    typedef struct packed {
        logic lo;
        logic hi;
        logic full;
    } gpo_sel_t;

    function automatic gpo_tgt_e decode_off(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_LO:   decode_off = TGT_LO;
            OFF_HI:   decode_off = TGT_HI;
            OFF_FULL: decode_off = TGT_FULL;
            default:  decode_off = TGT_NONE;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] keep_merge(
        input logic [HALF_W-1:0] keep,
        input logic [HALF_W-1:0] din,
        input logic [HALF_W-1:0] cur
    );
        keep_merge = (keep & cur) | (~keep & din);
    endfunction

endpackage

// File: rtl/gpo_addr_decode.sv
module gpo_addr_decode
    import gpo_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output gpo_sel_t          wr_sel,
    output gpo_tgt_e          tgt
);
    always_comb begin
        tgt         = decode_off(addr);
        wr_sel.lo   = wr_en && (tgt == TGT_LO);
        wr_sel.hi   = wr_en && (tgt == TGT_HI);
        wr_sel.full = wr_en && (tgt == TGT_FULL);
    end
endmodule

// File: rtl/gpo_half_lane.sv
module gpo_half_lane
    import gpo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mwr,
    input  logic [HALF_W-1:0] keep,
    input  logic [HALF_W-1:0] din,
    input  logic              fwr,
    input  logic [HALF_W-1:0] fdin,
    output logic [HALF_W-1:0] q
);
    logic [HALF_W-1:0] q_nxt;

    always_comb begin
        q_nxt = q;
        if (fwr)
            q_nxt = fdin;
        else if (mwr)
            q_nxt = keep_merge(keep, din, q);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    // Bits flagged "keep" must not move across a masked write (R2, R3, R9)
    assert_keep_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mwr && !fwr) |=> (((q ^ $past(q)) & $past(keep)) == '0));

    // Bits not flagged take the written data (R2, R3, R9)
    assert_load_free_R9: assert property (@(posedge clk) disable iff (rst)
        (mwr && !fwr) |=> (((q ^ $past(din)) & ~$past(keep)) == '0));
endmodule

// File: rtl/gpo_read_mux.sv
module gpo_read_mux
    import gpo_pkg::*;
(
    input  gpo_tgt_e          tgt,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (tgt)
            TGT_LO:   rdata = {{HALF_W{1'b0}}, cur[HALF_W-1:0]};
            TGT_HI:   rdata = {{HALF_W{1'b0}}, cur[DATA_W-1:HALF_W]};
            TGT_FULL: rdata = cur;
            default:  rdata = '0;
        endcase
    end

    // Keep flags are write-only: upper read half is zero for masked ports (R5)
    assert_rd_keep_zero_R5: assert final (!((tgt == TGT_LO || tgt == TGT_HI) && rdata[DATA_W-1:HALF_W] != '0));
    // Unmapped offsets read as zero (R8)
    assert_rd_unmapped_R8: assert final (!(tgt == TGT_NONE && rdata != '0));
endmodule

// File: rtl/gpo_mask_out.sv
module gpo_mask_out
    import gpo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] gpo_value
);
    gpo_sel_t sel;
    gpo_tgt_e tgt;
    logic [HALF_W-1:0] half_q [2];

    gpo_addr_decode u_dec (
        .addr  (bus_addr),
        .wr_en (bus_wr_en),
        .wr_sel(sel),
        .tgt   (tgt)
    );

    for (genvar h = 0; h < 2; h++) begin : g_lane
        gpo_half_lane u_lane (
            .clk (clk),
            .rst (rst),
            .mwr ((h == 0) ? sel.lo : sel.hi),
            .keep(bus_wdata[DATA_W-1:HALF_W]),
            .din (bus_wdata[HALF_W-1:0]),
            .fwr (sel.full),
            .fdin(bus_wdata[h*HALF_W +: HALF_W]),
            .q   (half_q[h])
        );
        assign gpo_value[h*HALF_W +: HALF_W] = half_q[h];
    end

    gpo_read_mux u_rd (
        .tgt  (tgt),
        .cur  (gpo_value),
        .rdata(bus_rdata)
    );

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (gpo_value == '0));

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> $stable(gpo_value));

    assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && decode_off(bus_addr) == TGT_NONE) |=> $stable(gpo_value));

    assert_hi_untouched_R2: assert property (@(posedge clk) disable iff (rst)
        sel.lo |=> $stable(gpo_value[DATA_W-1:HALF_W]));

    assert_lo_untouched_R3: assert property (@(posedge clk) disable iff (rst)
        sel.hi |=> $stable(gpo_value[HALF_W-1:0]));

    assert_full_load_R4: assert property (@(posedge clk) disable iff (rst)
        sel.full |=> (gpo_value == $past(bus_wdata)));
endmodule

// File: tb/test_gpo_mask_out.sv
module test_gpo_mask_out;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_wr_en;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] gpo_value;

    gpo_mask_out i_gpo_mask_out (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .gpo_value(gpo_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          drv_done = 0;
    logic [31:0] model;

    function automatic logic [15:0] mrg(input logic [15:0] k, input logic [15:0] d, input logic [15:0] c);
        return (k & c) | (~k & d);
    endfunction

    task automatic push(input bit rd, input logic [31:0] e, input string t);
        item_t it;
        it.is_read = rd; it.exp = e; it.tag = t;
        exp_q.push_back(it);
    endtask

    function automatic logic [31:0] rd_model(input logic [3:0] a);
        case (a)
            4'h0: return {16'h0, model[15:0]};
            4'h4: return {16'h0, model[31:16]};
            4'h8: return model;
            default: return 32'h0;
        endcase
    endfunction

    // Driver: applies a write, checks value is still old before the edge (R7),
    // then updates the model and queues the new output value.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string t);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        push(0, model, "R7");
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
        case (a)
            4'h0: model[15:0]  = mrg(d[31:16], d[15:0], model[15:0]);
            4'h4: model[31:16] = mrg(d[31:16], d[15:0], model[31:16]);
            4'h8: model = d;
            default: ;
        endcase
        push(0, model, t);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input string t);
        bus_addr = a;
        push(1, rd_model(a), t);
        @(negedge clk);
    endtask

    // Monitor: pops expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                act = it.is_read ? bus_rdata : gpo_value;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s actual=%h expected=%h", it.tag,
                             it.is_read ? "read" : "output", act, it.exp);
                end
            end
        end
    end

    initial begin
        rst = 1'b1; bus_addr = 4'h0; bus_wr_en = 1'b0; bus_wdata = 32'hFFFF_FFFF;
        model = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        push(0, 32'h0, "R1");
        rd(4'h8, "R1");

        wr(4'h8, 32'hA5A5_5A5A, "R4");  rd(4'h8, "R6");
        wr(4'h0, 32'h00FF_1234, "R2");  rd(4'h0, "R5");
        wr(4'h4, 32'hF0F0_BEEF, "R3");  rd(4'h4, "R5");
        wr(4'h0, 32'hFFFF_0000, "R9");  rd(4'h0, "R9");
        wr(4'h4, 32'h0000_C3C3, "R9");  rd(4'h8, "R6");
        wr(4'hC, 32'h0000_0000, "R8");  rd(4'hC, "R8");
        wr(4'h2, 32'h1234_5678, "R8");  rd(4'h2, "R8");

        // Idle bus with write data toggling: no change (R7)
        bus_addr = 4'h8; bus_wdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 4; i++) begin
            push(0, model, "R7");
            @(negedge clk);
            bus_wdata = ~bus_wdata;
        end

        for (int i = 0; i < 300; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            int          s;
            s = $urandom_range(0, 9);
            d = $urandom;
            a = (s < 4) ? 4'h0 : (s < 8) ? 4'h4 : (s == 8) ? 4'h8 : 4'($urandom_range(9, 15));
            wr(a, d, (a == 4'h0) ? "R2" : (a == 4'h4) ? "R3" : (a == 4'h8) ? "R4" : "R8");
            rd(4'($urandom_range(0, 15)), "R6");
        end

        // Reset mid-run returns to zero
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = 32'h0;
        push(0, 32'h0, "R1");
        @(negedge clk);
        @(negedge clk);
        drv_done = 1;
    end

    initial begin
        int cyc = 0;
        while (!drv_done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!drv_done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule